// File: doc/BRIEF.md
# Event Timer Register Front End and Main Counter

This block is the register front end of a high-precision event timer with several comparator channels. It decodes 32-bit accesses in a 1 KiB window. Locally it holds the capability words, the global configuration and the 64-bit main counter. Accesses that fall in the per-channel area are passed to the channel that owns the 32-byte slot. The channels themselves sit outside this block.

The main counter advances by one on each tick strobe, but only while the global enable is set. When the enable rises, every channel whose comparator is not all ones is told to arm. When the enable falls, every channel is told to disarm.

Each channel reports an expiry pulse. The block forwards that pulse to one of the interrupt lines, chosen by the channel's route field. When legacy routing is active, channels 0 and 1 go to fixed lines instead. While legacy routing is active, the block also holds an inhibit output that silences an older interval timer.

Top module: `evt_timer_regs`

## Requirements
- R1: Word 0x000 reads the capability value {16'h8086, bit15=1 legacy capable, bit14=0, bit13=1 64-bit counter, bits12:8 = channel count minus one, 8'h01}, which is 0x8086A201 for three channels. Word 0x004 reads the tick period in femtoseconds. Writes to either word change nothing.
- R2: At 0x010, bit 0 is the global enable and bit 1 is the legacy-route bit. All other bits read 0. Word 0x014 and the status word 0x020 always read 0 and ignore writes.
- R3: The 64-bit counter increments once per edge on which the enable was set and tick_en is high. While the enable is clear, it keeps its value.
- R4: Word 0x0F0 writes the counter's low half and 0x0F4 its high half, at any time, even while the counter runs. On the edge of the write, the write takes priority over the increment.
- R5: A write that takes the enable from 0 to 1 gives a one-cycle ch_arm pulse. The pulse covers exactly the channels whose ch_cmp_max is low, and it appears in the cycle after the write. Writing 1 while the enable is already 1 gives no pulse.
- R6: A write that takes the enable from 1 to 0 gives a one-cycle ch_disarm pulse on every channel.
- R7: Addresses 0x100 to 0x3FF select channel (addr-0x100)/0x20. A 32-bit write raises that channel's ch_wr bit during the access cycle and presents ch_addr = addr[4:0] and ch_wdata. A read returns that channel's ch_rdata.
- R8: A slot at or beyond NUM_CH reads 0 and raises no ch_wr bit.
- R9: Any access with req_size other than 2'b10 (32-bit) is dropped. As a write it changes no state. As a read it returns 0.
- R10: With the legacy bit clear, each channel's pulse goes to the line named by its own ch_route field. With the bit set, channel 0 uses line 0 and channel 1 uses line 8, while the other channels keep their own route.
- R11: A ch_fire pulse appears on irq_out as a one-cycle pulse in the next cycle, and only while the global enable is set.
- R12: pit_inhibit is 1 after power-up. It is set when the legacy bit rises and cleared when the bit falls. A system reset (rst_n low while por_n is high) clears it.
- R13: Reset clears the counter and the global configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, active low, asynchronous |
| rst_n | input | 1 | System reset, active low, asynchronous |
| tick_en | input | 1 | Counter tick strobe |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 2'b10 = 32-bit; other codes are narrow accesses |
| req_addr | input | 10 | Byte address in the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_data | output | 32 | Read data |
| main_count | output | 64 | Main counter |
| glb_en | output | 1 | Global enable |
| legacy_mode | output | 1 | Legacy routing active |
| pit_inhibit | output | 1 | Inhibit for the older interval timer |
| ch_wr | output | NUM_CH | Per-channel write strobe |
| ch_addr | output | 5 | Byte offset inside the channel slot |
| ch_wdata | output | 32 | Write data to channels |
| ch_rdata | input | NUM_CH*32 | Read data from the channels |
| ch_cmp_max | input | NUM_CH | Channel comparator is all ones |
| ch_arm | output | NUM_CH | Arm pulse per channel |
| ch_disarm | output | NUM_CH | Disarm pulse per channel |
| ch_route | input | NUM_CH*ROUTE_W | Route field of each channel |
| ch_fire | input | NUM_CH | Channel expiry pulse |
| irq_out | output | NUM_LINES | Interrupt line pulses |

## Verification
The bench builds the block with its defaults: three channels, 32 lines, a 5-bit route field and a 10,000,000 fs period. These defaults give a capability word that can be compared to the literal 0x8086A201. Slots 3 to 23 stay empty, so the bench can check that out-of-range reads return 0 and out-of-range writes are dropped. Both legacy lines, 0 and 8, and a high route line, 20, exist, so the legacy override can be seen next to a normal route. The counter is preset near a 32-bit boundary to check the carry into the high half.

// File: rtl/evt_timer_regs.sv
module evt_timer_regs #(
  parameter int NUM_CH = 3,
  parameter int NUM_LINES = 32,
  parameter int ROUTE_W = 5,
  parameter logic [31:0] TICK_FS = 32'd10_000_000
) (
  input  logic                        clk,
  input  logic                        por_n,
  input  logic                        rst_n,
  input  logic                        tick_en,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [1:0]                  req_size,
  input  logic [9:0]                  req_addr,
  input  logic [31:0]                 req_wdata,
  output logic                        rsp_valid,
  output logic [31:0]                 rsp_data,
  output logic [63:0]                 main_count,
  output logic                        glb_en,
  output logic                        legacy_mode,
  output logic                        pit_inhibit,
  output logic [NUM_CH-1:0]           ch_wr,
  output logic [4:0]                  ch_addr,
  output logic [31:0]                 ch_wdata,
  input  logic [NUM_CH*32-1:0]        ch_rdata,
  input  logic [NUM_CH-1:0]           ch_cmp_max,
  output logic [NUM_CH-1:0]           ch_arm,
  output logic [NUM_CH-1:0]           ch_disarm,
  input  logic [NUM_CH*ROUTE_W-1:0]   ch_route,
  input  logic [NUM_CH-1:0]           ch_fire,
  output logic [NUM_LINES-1:0]        irq_out
);

  localparam logic [4:0]  NCH5   = 5'(NUM_CH);
  localparam logic [31:0] CAP_LO = {16'h8086, 1'b1, 1'b0, 1'b1, 5'(NUM_CH - 1), 8'h01};
  localparam int LEG_LINE0 = 0;
  localparam int LEG_LINE1 = 8;
  localparam logic [1:0] SZ_WORD = 2'b10;

  logic        word_ok, acc_wr, acc_rd;
  logic [7:0]  word;
  logic        in_ch, slot_ok;
  logic [4:0]  slot;
  logic        cfg_wr, cnt_lo_wr, cnt_hi_wr;
  logic        en_q, leg_q;
  logic [63:0] cnt_q;
  logic [31:0] rd_next;

  assign word_ok = req_valid && (req_size == SZ_WORD);
  assign acc_wr  = word_ok && req_write;
  assign acc_rd  = word_ok && !req_write;
  assign word    = req_addr[9:2];
  assign in_ch   = req_addr[9:8] != 2'b00;
  assign slot    = req_addr[9:5] - 5'd8;
  assign slot_ok = in_ch && (slot < NCH5);

  assign cfg_wr    = acc_wr && !in_ch && (word == 8'h04);
  assign cnt_lo_wr = acc_wr && !in_ch && (word == 8'h3C);
  assign cnt_hi_wr = acc_wr && !in_ch && (word == 8'h3D);

  assign ch_addr  = req_addr[4:0];
  assign ch_wdata = req_wdata;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_wr
    assign ch_wr[i] = acc_wr && slot_ok && (slot == 5'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_lo_wr)
      cnt_q[31:0] <= req_wdata;
    else if (cnt_hi_wr)
      cnt_q[63:32] <= req_wdata;
    else if (en_q && tick_en)
      cnt_q <= cnt_q + 64'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      leg_q     <= 1'b0;
      ch_arm    <= '0;
      ch_disarm <= '0;
    end else begin
      ch_arm    <= '0;
      ch_disarm <= '0;
      if (cfg_wr) begin
        en_q  <= req_wdata[0];
        leg_q <= req_wdata[1];
        if (!en_q && req_wdata[0])
          ch_arm <= ~ch_cmp_max;
        else if (en_q && !req_wdata[0])
          ch_disarm <= '1;
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      pit_inhibit <= 1'b1;
    else if (!rst_n)
      pit_inhibit <= 1'b0;
    else if (cfg_wr && !leg_q && req_wdata[1])
      pit_inhibit <= 1'b1;
    else if (cfg_wr && leg_q && !req_wdata[1])
      pit_inhibit <= 1'b0;
  end

  always_comb begin
    rd_next = '0;
    if (in_ch) begin
      for (int i = 0; i < NUM_CH; i++)
        if (slot_ok && slot == 5'(i)) rd_next = ch_rdata[i*32 +: 32];
    end else begin
      case (word)
        8'h00: rd_next = CAP_LO;
        8'h01: rd_next = TICK_FS;
        8'h04: rd_next = {30'd0, leg_q, en_q};
        8'h3C: rd_next = cnt_q[31:0];
        8'h3D: rd_next = cnt_q[63:32];
        default: rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write)
        rsp_data <= acc_rd ? rd_next : 32'd0;
    end
  end

  logic [ROUTE_W-1:0]   eff [NUM_CH];
  logic [NUM_LINES-1:0] hit;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_route
    logic [ROUTE_W-1:0] own;
    assign own = ch_route[i*ROUTE_W +: ROUTE_W];
    if (i == 0) begin : g_l0
      assign eff[i] = leg_q ? ROUTE_W'(LEG_LINE0) : own;
    end else if (i == 1) begin : g_l1
      assign eff[i] = leg_q ? ROUTE_W'(LEG_LINE1) : own;
    end else begin : g_own
      assign eff[i] = own;
    end
  end

  always_comb begin
    hit = '0;
    for (int l = 0; l < NUM_LINES; l++)
      for (int i = 0; i < NUM_CH; i++)
        if (ch_fire[i] && eff[i] == ROUTE_W'(l)) hit[l] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= '0;
    else        irq_out <= en_q ? hit : '0;
  end

  assign main_count  = cnt_q;
  assign glb_en      = en_q;
  assign legacy_mode = leg_q;

endmodule

// File: rtl/evt_timer_regs_chk.sv
module evt_timer_regs_chk #(
  parameter int NUM_CH = 3,
  parameter int NUM_LINES = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_write,
  input logic [1:0]           req_size,
  input logic [6:0]           req_dword,
  input logic                 tick_en,
  input logic [63:0]          main_count,
  input logic                 glb_en,
  input logic                 legacy_mode,
  input logic                 pit_inhibit,
  input logic [NUM_CH-1:0]    ch_wr,
  input logic [NUM_CH-1:0]    ch_cmp_max,
  input logic [NUM_CH-1:0]    ch_arm,
  input logic [NUM_CH-1:0]    ch_disarm,
  input logic [NUM_LINES-1:0] irq_out
);
  logic cnt_touch;
  assign cnt_touch = req_valid && req_write && req_size == 2'b10 && req_dword == 7'h1E;

  assert_halt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !cnt_touch) |=> $stable(main_count));
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en && tick_en && !cnt_touch) |=> main_count == $past(main_count) + 64'd1);
  assert_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(glb_en) |-> ch_arm == ~$past(ch_cmp_max));
  assert_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(glb_en) |-> &ch_disarm);
  assert_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_wr));
  assert_narrow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != 2'b10) |-> ch_wr == '0);
  assert_narrow_cfg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != 2'b10) |=> ($stable(glb_en) && $stable(legacy_mode)));
  assert_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_out) |-> $past(glb_en));
  assert_pit_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(legacy_mode) |-> pit_inhibit);
  assert_pit_clr_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(legacy_mode) |-> !pit_inhibit);
endmodule

bind evt_timer_regs evt_timer_regs_chk #(.NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_size(req_size), .req_dword(req_addr[9:3]), .tick_en(tick_en),
  .main_count(main_count), .glb_en(glb_en), .legacy_mode(legacy_mode),
  .pit_inhibit(pit_inhibit), .ch_wr(ch_wr), .ch_cmp_max(ch_cmp_max),
  .ch_arm(ch_arm), .ch_disarm(ch_disarm), .irq_out(irq_out)
);

// File: tb/evt_timer_regs_bench.sv
module evt_timer_regs_bench;
  localparam int NCH = 3, NL = 32, RW = 5;

  logic clk = 1'b0, por_n = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_size = 2'b10;
  logic [9:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_data;
  logic [63:0] main_count;
  logic glb_en, legacy_mode, pit_inhibit;
  logic [NCH-1:0] ch_wr, ch_arm, ch_disarm;
  logic [NCH-1:0] ch_cmp_max = 3'b010, ch_fire = '0;
  logic [4:0] ch_addr;
  logic [31:0] ch_wdata;
  logic [NCH*32-1:0] ch_rdata;
  logic [NCH*RW-1:0] ch_route = {5'd20, 5'd7, 5'd3};
  logic [NL-1:0] irq_out;

  int checks = 0, errors = 0;
  logic finished = 1'b0;
  logic [NCH-1:0] wr_seen;
  logic [31:0] wd_seen;

  always #5 clk = ~clk;

  always_comb
    for (int i = 0; i < NCH; i++)
      ch_rdata[i*32 +: 32] = {8'hC0 + 8'(i), 19'd0, ch_addr};

  evt_timer_regs u_evt_timer_regs (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick_en(tick_en),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .main_count(main_count), .glb_en(glb_en),
    .legacy_mode(legacy_mode), .pit_inhibit(pit_inhibit), .ch_wr(ch_wr),
    .ch_addr(ch_addr), .ch_wdata(ch_wdata), .ch_rdata(ch_rdata),
    .ch_cmp_max(ch_cmp_max), .ch_arm(ch_arm), .ch_disarm(ch_disarm),
    .ch_route(ch_route), .ch_fire(ch_fire), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [9:0] a, input logic [31:0] d, input logic [1:0] sz = 2'b10);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_size = sz;
    #1;
    wr_seen = ch_wr; wd_seen = ch_wdata;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_size = 2'b10;
  endtask

  task automatic bus_rd(input logic [9:0] a, output logic [31:0] d, input logic [1:0] sz = 2'b10);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
    @(negedge clk);
    d = rsp_valid ? rsp_data : 32'hDEAD_BEEF;
    req_valid = 1'b0; req_size = 2'b10;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R12 pit_inhibit after power-up", 64'(pit_inhibit), 64'd1);
    chk("R13 glb_en after reset", 64'(glb_en), 64'd0);
    bus_rd(10'h010, d); chk("R13 config after reset", 64'(d), 64'd0);
    bus_rd(10'h0F0, d); chk("R13 counter low after reset", 64'(d), 64'd0);
  endtask

  task automatic t_cap;
    logic [31:0] d;
    bus_rd(10'h000, d); chk("R1 capability low", 64'(d), 64'h8086A201);
    bus_rd(10'h004, d); chk("R1 period word", 64'(d), 64'd10_000_000);
    bus_wr(10'h000, 32'h0);
    bus_rd(10'h000, d); chk("R1 capability after write", 64'(d), 64'h8086A201);
  endtask

  task automatic t_cfg;
    logic [31:0] d;
    bus_wr(10'h010, 32'hFFFF_FFFC);
    bus_rd(10'h010, d); chk("R2 reserved config bits", 64'(d), 64'd0);
    bus_wr(10'h014, 32'hFFFF_FFFF);
    bus_rd(10'h014, d); chk("R2 config upper word", 64'(d), 64'd0);
    bus_wr(10'h020, 32'hFFFF_FFFF);
    bus_rd(10'h020, d); chk("R2 status ignores writes", 64'(d), 64'd0);
  endtask

  task automatic t_narrow;
    logic [31:0] d;
    bus_wr(10'h010, 32'h3, 2'b00);
    chk("R9 narrow write no strobe", 64'(wr_seen), 64'd0);
    bus_rd(10'h010, d); chk("R9 narrow config write dropped", 64'(d), 64'd0);
    bus_rd(10'h000, d, 2'b01); chk("R9 narrow read is zero", 64'(d), 64'd0);
    bus_wr(10'h128, 32'h55, 2'b01);
    chk("R9 narrow channel write dropped", 64'(wr_seen), 64'd0);
  endtask

  task automatic t_chan;
    logic [31:0] d;
    bus_rd(10'h148, d); chk("R7 channel 2 read", 64'(d), 64'hC200_0008);
    bus_rd(10'h10C, d); chk("R7 channel 0 read", 64'(d), 64'hC000_000C);
    bus_wr(10'h128, 32'h1234_5678);
    chk("R7 channel 1 write strobe", 64'(wr_seen), 64'b010);
    chk("R7 channel write data", 64'(wd_seen), 64'h1234_5678);
    bus_rd(10'h160, d); chk("R8 slot 3 reads zero", 64'(d), 64'd0);
    bus_wr(10'h3E0, 32'hFFFF_FFFF);
    chk("R8 slot 23 write dropped", 64'(wr_seen), 64'd0);
  endtask

  task automatic t_counter;
    logic [31:0] d, d2;
    tick_en = 1'b1;
    bus_wr(10'h0F0, 32'hFFFF_FFFE);
    bus_wr(10'h0F4, 32'h0000_0001);
    repeat (3) @(negedge clk);
    bus_rd(10'h0F0, d); chk("R3 held while disabled", 64'(d), 64'hFFFF_FFFE);
    tick_en = 1'b0;
    bus_wr(10'h010, 32'h1);
    tick_en = 1'b1;
    repeat (3) @(negedge clk);
    tick_en = 1'b0;
    bus_rd(10'h0F0, d); chk("R3 low after 3 ticks", 64'(d), 64'h1);
    bus_rd(10'h0F4, d); chk("R3 carry into high", 64'(d), 64'h2);
    tick_en = 1'b1;
    bus_wr(10'h0F0, 32'h100);
    tick_en = 1'b0;
    bus_rd(10'h0F0, d); chk("R4 write wins over tick", 64'(d), 64'h100);
    bus_rd(10'h0F4, d); chk("R4 high half kept", 64'(d), 64'h2);
    bus_wr(10'h010, 32'h0);
    tick_en = 1'b1;
    bus_rd(10'h0F0, d);
    repeat (4) @(negedge clk);
    bus_rd(10'h0F0, d2);
    tick_en = 1'b0;
    chk("R3 frozen after disable", 64'(d2), 64'(d));
  endtask

  task automatic t_arm;
    bus_wr(10'h010, 32'h1);
    chk("R5 arm pulse", 64'(ch_arm), 64'b101);
    chk("R5 no disarm on rise", 64'(ch_disarm), 64'd0);
    @(negedge clk);
    chk("R5 arm is one cycle", 64'(ch_arm), 64'd0);
    bus_wr(10'h010, 32'h1);
    chk("R5 no arm without edge", 64'(ch_arm), 64'd0);
    bus_wr(10'h010, 32'h0);
    chk("R6 disarm all", 64'(ch_disarm), 64'b111);
    @(negedge clk);
    chk("R6 disarm is one cycle", 64'(ch_disarm), 64'd0);
  endtask

  task automatic fire(input logic [NCH-1:0] f, input logic [NL-1:0] exp, input string req);
    @(negedge clk);
    ch_fire = f;
    @(negedge clk);
    ch_fire = '0;
    chk(req, 64'(irq_out), 64'(exp));
    @(negedge clk);
    chk("R11 pulse lasts one cycle", 64'(irq_out), 64'd0);
  endtask

  task automatic t_irq;
    bus_wr(10'h010, 32'h1);
    fire(3'b001, 32'h0000_0008, "R10 channel 0 own route");
    fire(3'b110, 32'h0010_0080, "R10 channels 1 and 2 own routes");
    bus_wr(10'h010, 32'h3);
    fire(3'b111, 32'h0010_0101, "R10 legacy override");
    bus_wr(10'h010, 32'h2);
    fire(3'b111, 32'h0, "R11 gated while disabled");
  endtask

  task automatic t_pit;
    logic [31:0] d;
    chk("R12 inhibit with legacy set", 64'(pit_inhibit), 64'd1);
    bus_wr(10'h010, 32'h0);
    chk("R12 released on legacy clear", 64'(pit_inhibit), 64'd0);
    bus_wr(10'h010, 32'h2);
    chk("R12 set on legacy rise", 64'(pit_inhibit), 64'd1);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk("R12 released by system reset", 64'(pit_inhibit), 64'd0);
    bus_rd(10'h010, d); chk("R13 config cleared by reset", 64'(d), 64'd0);
    bus_rd(10'h0F4, d); chk("R13 counter cleared by reset", 64'(d), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_cap;
    t_cfg;
    t_narrow;
    t_chan;
    t_counter;
    t_arm;
    t_irq;
    t_pit;
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule